// File: doc/BRIEF.md
# Systolic FIR Tap Chain

This block is a finite impulse response filter built as a chain of identical taps. Each tap multiplies one sample by its own coefficient and adds the product to the partial sum coming from the tap before it. Samples travel down the chain through two registers per tap (an input register and a delay register), while partial sums move through one register per tap. This skew aligns each sum with the sample it must meet, so the last tap produces the direct-form convolution. A registered result leaves the block.

Coefficients enter one word at a time on a load strobe and shift into per-tap registers. The first tap takes its sample either from the direct sample input or from a cascade input. The cascade input lets one chain feed another. The sample leaving the last delay register is presented on a cascade output. One clock enable stalls the whole data path, and a synchronous clear empties it. With the default parameters the products are 18x19 signed, the chain sum is 44 bits wide and at most 16 taps are allowed. With the wide parameter set the products are 27x27 signed, the sum is 64 bits wide and at most 11 taps are allowed.

Top module: `fir_systolic_chain`

## Requirements
- R1: After the asynchronous reset, `y_o` and `casc_o` are zero.
- R2: Let x(t) be the sample captured at the t-th enabled clock edge. The output after edge t is y(t) = sum over j of c_j * x(t-1-N-j), for j = 0 to N-1. N is `NTAPS`, c_j is the coefficient of tap j, and all arithmetic is signed two's complement in the chain-sum width. A sample therefore first reaches `y_o` N+1 enabled edges after the edge that captures it.
- R3: Each edge with `coef_ld_i` high shifts `coef_i` into tap 0 and moves every coefficient one tap toward tap N-1. After N strobes, the word given at the first strobe is c_{N-1} and the word given at the last strobe is c_0. Loading does not depend on `ce_i` or `clr_i`.
- R4: While `ce_i` is low and `clr_i` is low, the sample, delay, sum and output registers hold. `y_o` and `casc_o` stay constant, whatever the sample inputs do.
- R5: `clr_i` high at an edge zeroes every sample, delay, sum and output register, whatever the value of `ce_i`. The coefficients are kept.
- R6: `src_sel_i` = 1 selects `casc_i` as the sample for tap 0, and `smp_i` is then ignored. `src_sel_i` = 0 selects `smp_i`.
- R7: `casc_o` after edge t equals x(t-2N+1). It is the sample from the delay register of the last tap.
- R8: Default widths: 18-bit samples, 19-bit coefficients and a 44-bit sum. This leaves 7 guard bits over the 37-bit product, so N full-scale products (N at most 16) add up without wrapping. With `WIDE` = 1 the widths are 27, 27 and 64, and N is at most 11. A larger N stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Clock enable for the data path |
| clr_i | input | 1 | Synchronous clear of the data path |
| src_sel_i | input | 1 | Tap 0 sample source: 0 = smp_i, 1 = casc_i |
| smp_i | input | SMP_W (18) | Direct sample input, signed |
| casc_i | input | SMP_W (18) | Cascade sample input, signed |
| coef_i | input | COEF_W (19) | Coefficient word, signed |
| coef_ld_i | input | 1 | Coefficient shift strobe |
| y_o | output | SUM_W (44) | Filtered output, signed |
| casc_o | output | SMP_W (18) | Sample from the delay register of the last tap |

## Verification
A sample captured at an enabled edge appears in `y_o`, weighted by c_0, N+1 enabled edges later. The same sample reaches `casc_o` 2N-1 enabled edges later. Clear and hold take effect at the very next edge. The bench drives its inputs at the falling edge. At each rising edge it shifts the selected sample into a history model of its own, and it compares the outputs at the following falling edge. The expected values therefore come from the convolution formula of R2 and R7, not from counting the registers inside the taps. Stalled edges leave the model unchanged, and a clear empties it, which matches R4 and R5.

// File: rtl/fir_pkg.sv
package fir_pkg;
  function automatic int smp_width(input bit wide);
    return wide ? 27 : 18;
  endfunction
  function automatic int coef_width(input bit wide);
    return wide ? 27 : 19;
  endfunction
  function automatic int sum_width(input bit wide);
    return wide ? 64 : 44;
  endfunction
  function automatic int max_taps(input bit wide);
    return wide ? 11 : 16;
  endfunction
endpackage

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
  parameter int NTAPS  = 8,
  parameter int COEF_W = 19
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         ld_i,
  input  logic [COEF_W-1:0]            coef_i,
  output logic [NTAPS-1:0][COEF_W-1:0] coef_o
);
  logic [NTAPS-1:0][COEF_W-1:0] coef_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) coef_q <= '0;
    else if (ld_i) begin
      coef_q[0] <= coef_i;
      for (int k = 1; k < NTAPS; k++) coef_q[k] <= coef_q[k-1];
    end
  end

  assign coef_o = coef_q;

  // R3
  coef_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(coef_o));

  generate
    if (NTAPS >= 2) begin : g_shift_chk
      // R3
      coef_walk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld_i ##1 ld_i |=> coef_o[1] == $past(coef_i, 2));
    end
  endgenerate
endmodule

// File: rtl/fir_tap.sv
module fir_tap #(
  parameter int SMP_W  = 18,
  parameter int COEF_W = 19,
  parameter int SUM_W  = 44
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ce_i,
  input  logic                     clr_i,
  input  logic signed [SMP_W-1:0]  smp_i,
  input  logic signed [COEF_W-1:0] coef_i,
  input  logic signed [SUM_W-1:0]  sum_i,
  output logic signed [SMP_W-1:0]  smp_o,
  output logic signed [SUM_W-1:0]  sum_o
);
  localparam int PROD_W  = SMP_W + COEF_W;
  localparam int GUARD_W = SUM_W - PROD_W;

  logic signed [SMP_W-1:0]  in_q, dly_q;
  logic signed [SUM_W-1:0]  sum_q;
  logic signed [PROD_W-1:0] prod;
  logic signed [SUM_W-1:0]  prod_ext;

  assign prod     = in_q * coef_i;
  assign prod_ext = {{GUARD_W{prod[PROD_W-1]}}, prod};

  // input and delay registers share one enable by construction
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      dly_q <= '0;
      sum_q <= '0;
    end else if (clr_i) begin
      in_q  <= '0;
      dly_q <= '0;
      sum_q <= '0;
    end else if (ce_i) begin
      in_q  <= smp_i;
      dly_q <= in_q;
      sum_q <= sum_i + prod_ext;
    end
  end

  assign smp_o = dly_q;
  assign sum_o = sum_q;

  // R4
  ce_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_i && !clr_i) |=> ($stable(smp_o) && $stable(sum_o)));

  // R5
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (smp_o == '0 && sum_o == '0));

  // R7
  delay_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && !clr_i) ##1 (ce_i && !clr_i) |=> smp_o == $past(smp_i, 2));
endmodule

// File: rtl/fir_systolic_chain.sv
module fir_systolic_chain
  import fir_pkg::*;
#(
  parameter bit WIDE  = 1'b0,
  parameter int NTAPS = 8,
  localparam int SMP_W  = smp_width(WIDE),
  localparam int COEF_W = coef_width(WIDE),
  localparam int SUM_W  = sum_width(WIDE)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ce_i,
  input  logic                     clr_i,
  input  logic                     src_sel_i,
  input  logic signed [SMP_W-1:0]  smp_i,
  input  logic signed [SMP_W-1:0]  casc_i,
  input  logic signed [COEF_W-1:0] coef_i,
  input  logic                     coef_ld_i,
  output logic signed [SUM_W-1:0]  y_o,
  output logic signed [SMP_W-1:0]  casc_o
);
  localparam int MAX_TAPS = max_taps(WIDE);

  generate
    if (NTAPS < 1 || NTAPS > MAX_TAPS) begin : g_bad_taps
      $error("NTAPS exceeds guard-bit headroom of the chain sum");
    end
  endgenerate

  logic [NTAPS-1:0][COEF_W-1:0] coef;
  logic signed [SMP_W-1:0]      smp_chain [NTAPS+1];
  logic signed [SUM_W-1:0]      sum_chain [NTAPS+1];
  logic signed [SUM_W-1:0]      y_q;

  fir_coef_bank #(.NTAPS(NTAPS), .COEF_W(COEF_W)) u_coef (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (coef_ld_i),
    .coef_i (coef_i),
    .coef_o (coef)
  );

  assign smp_chain[0] = src_sel_i ? casc_i : smp_i;
  assign sum_chain[0] = '0;

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    fir_tap #(.SMP_W(SMP_W), .COEF_W(COEF_W), .SUM_W(SUM_W)) u_tap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ce_i   (ce_i),
      .clr_i  (clr_i),
      .smp_i  (smp_chain[k]),
      .coef_i (coef[k]),
      .sum_i  (sum_chain[k]),
      .smp_o  (smp_chain[k+1]),
      .sum_o  (sum_chain[k+1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    y_q <= '0;
    else if (clr_i) y_q <= '0;
    else if (ce_i)  y_q <= sum_chain[NTAPS];
  end

  assign y_o    = y_q;
  assign casc_o = smp_chain[NTAPS];

  // R4
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_i && !clr_i) |=> ($stable(y_o) && $stable(casc_o)));

  // R5
  out_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (y_o == '0 && casc_o == '0));
endmodule

// File: tb/tb_fir_systolic_chain.sv
module tb_fir_systolic_chain;
  localparam int NT   = 8;
  localparam int SW   = 18;
  localparam int CW   = 19;
  localparam int SUMW = 44;
  localparam int HL   = 3 * NT + 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ce_i = 1'b0, clr_i = 1'b0, src_sel_i = 1'b0, coef_ld_i = 1'b0;
  logic signed [SW-1:0] smp_i = '0, casc_i = '0;
  logic signed [CW-1:0] coef_i = '0;
  logic signed [SUMW-1:0] y_o;
  logic signed [SW-1:0] casc_o;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  longint h [NT];
  longint hist [HL];

  always #4 clk_i = ~clk_i;

  fir_systolic_chain #(.WIDE(1'b0), .NTAPS(NT)) dut (
    .clk_i, .rst_ni, .ce_i, .clr_i, .src_sel_i, .smp_i, .casc_i,
    .coef_i, .coef_ld_i, .y_o, .casc_o
  );

  // reference model, updated at each rising edge
  always @(posedge clk_i) begin
    if (rst_ni) begin
      if (clr_i) begin
        for (int k = 0; k < HL; k++) hist[k] = 0;
      end else if (ce_i) begin
        for (int k = HL - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = src_sel_i ? longint'(casc_i) : longint'(smp_i);
      end
    end
  end

  function automatic longint exp_y();
    longint acc = 0;
    for (int j = 0; j < NT; j++) acc += h[j] * hist[1 + NT + j];
    return acc;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_outputs(input string req);
    longint e = exp_y();
    logic signed [SUMW-1:0] e_w = e[SUMW-1:0];
    chk(y_o === e_w, req, longint'(y_o), longint'(e_w));
    chk(casc_o === SW'(hist[2*NT-1]), {req, " casc_o"}, longint'(casc_o), hist[2*NT-1]);
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic load_coefs();
    for (int i = NT - 1; i >= 0; i--) begin
      coef_i = CW'(h[i]);
      coef_ld_i = 1'b1;
      step();
    end
    coef_ld_i = 1'b0;
  endtask

  task automatic clear();
    clr_i = 1'b1;
    step();
    clr_i = 1'b0;
  endtask

  task automatic t_reset();
    chk(y_o === '0, "R1 y_o", longint'(y_o), 0);
    chk(casc_o === '0, "R1 casc_o", longint'(casc_o), 0);
  endtask

  task automatic t_impulse();
    bit seen = 1'b0;
    for (int j = 0; j < NT; j++) h[j] = (j % 2 == 0) ? longint'(3 + 5 * j) : -longint'(7 + 2 * j);
    load_coefs();
    clear();
    ce_i = 1'b1;
    smp_i = 18'sd1;
    step();
    smp_i = '0;
    for (int k = 1; k < 2 * NT + 4; k++) begin
      step();
      check_outputs("R2/R3 impulse");
      if (k == NT + 1) begin
        seen = 1'b1;
        chk(y_o == SUMW'(h[0]), "R3 first tap weight", longint'(y_o), h[0]);
      end
    end
    chk(seen, "R2 impulse window", 0, 0);
  endtask

  task automatic t_stream();
    logic [15:0] lfsr = 16'hACE1;
    ce_i = 1'b1;
    for (int k = 0; k < 48; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      smp_i = SW'($signed({lfsr, 2'b01}));
      step();
      check_outputs("R2 stream");
    end
  endtask

  task automatic t_hold();
    logic signed [SUMW-1:0] y_keep;
    logic signed [SW-1:0] c_keep;
    smp_i = 18'sd1234;
    step();
    y_keep = y_o;
    c_keep = casc_o;
    ce_i = 1'b0;
    for (int k = 0; k < 5; k++) begin
      smp_i = SW'(k * 9001 - 20000);
      step();
      chk(y_o === y_keep, "R4 y_o hold", longint'(y_o), longint'(y_keep));
      chk(casc_o === c_keep, "R4 casc_o hold", longint'(casc_o), longint'(c_keep));
    end
    ce_i = 1'b1;
    for (int k = 0; k < 6; k++) begin
      smp_i = SW'(k * 311 - 700);
      step();
      check_outputs("R4 resume");
    end
  endtask

  task automatic t_clear();
    ce_i = 1'b0;
    clr_i = 1'b1;
    step();
    clr_i = 1'b0;
    chk(y_o === '0, "R5 y_o cleared", longint'(y_o), 0);
    chk(casc_o === '0, "R5 casc_o cleared", longint'(casc_o), 0);
    ce_i = 1'b1;
    smp_i = -18'sd2;
    step();
    smp_i = '0;
    for (int k = 1; k < NT + 3; k++) begin
      step();
      check_outputs("R5 coefficients kept");
    end
  endtask

  task automatic t_source();
    src_sel_i = 1'b1;
    for (int k = 0; k < 2 * NT + 4; k++) begin
      casc_i = SW'(k * 1777 - 9000);
      smp_i = SW'(-31000 + k);
      step();
      check_outputs("R6/R7 cascade source");
    end
    src_sel_i = 1'b0;
  endtask

  task automatic t_fullscale();
    longint pos = longint'(NT) * (longint'(1) << 35);
    for (int j = 0; j < NT; j++) h[j] = -(longint'(1) << 18);
    ce_i = 1'b0;
    load_coefs();
    clear();
    ce_i = 1'b1;
    smp_i = -18'sd131072;
    for (int k = 0; k < 2 * NT + 4; k++) begin
      step();
      check_outputs("R8 full scale");
    end
    chk(y_o == SUMW'(pos) && y_o > 0, "R8 no wrap", longint'(y_o), pos);
  endtask

  initial begin
    for (int k = 0; k < HL; k++) hist[k] = 0;
    for (int j = 0; j < NT; j++) h[j] = 0;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_impulse();
    t_stream();
    t_hold();
    t_clear();
    t_source();
    t_fullscale();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule